// File: doc/BRIEF.md
# Two-Phase Discharge-Ratio Resistance Sequencer

This block runs a resistance measurement in two timed phases. It charges a known capacitor and then lets it discharge through the resistor under test. It counts clock cycles until an external comparator reports that the capacitor voltage has fallen below its threshold. It then recharges the capacitor, discharges it through a reference resistor of known value, and times that discharge as well. Because both discharges use the same capacitor and the same threshold, the unknown resistance equals the reference value multiplied by the ratio of the two times.

The block drives three switch enables (charge, unknown path, reference path) and reads one comparator level. After the second phase, a shift-subtract divider computes `r_ref * t_unknown / t_reference` one quotient bit per cycle and presents the result with a single-cycle valid strobe. Each discharge phase has a cycle limit. A comparator that never trips ends the run with a one-cycle error strobe and no result.

Top module: `rr_ratio_meter`

## Requirements
- R1: After reset, all switch enables, `busy`, `res_valid` and `tmo_err` are low.
- R2: A high `start` sampled while idle begins a charge interval in the next cycle. During it only `chg_en` is high, and it lasts max(`chg_cycles`,1) cycles.
- R3: After the first charge interval, `sel_unk` alone is high. It ends after the first cycle whose closing clock edge samples `comp_hi` low. The unknown time t_u is the number of cycles `sel_unk` was high, counting that last one.
- R4: `sel_unk` and `sel_ref` are never high together, and `chg_en` is never high with either of them. Exactly one cycle with all three low (and `busy` high) separates the end of the unknown discharge from the second charge.
- R5: After the dead cycle, a second charge interval of the same length runs. It is followed by the reference discharge on `sel_ref`, timed into t_r in the same way as R3.
- R6: After the last `sel_ref` cycle, `busy` stays high with all switches off for OUT_W+2 cycles, where OUT_W = TIME_W+RREF_W. In the next cycle `busy` is low and `res_valid` is high for exactly one cycle, with `res_ohm` = floor(`r_ref` × t_u / t_r).
- R7: If `comp_hi` is still high at the end of discharge cycle k with k ≥ `tmo_limit`, the next cycle is idle with `tmo_err` high for one cycle and no `res_valid`. This applies in either phase, and a limit of 0 acts as 1.
- R8: A comparator trip in the same cycle that reaches the limit counts as a trip, not a timeout.
- R9: `start` is ignored while `busy` is high.
- R10: `comp_hi` is ignored outside the discharge phases, including a low level during charging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a measurement when idle |
| comp_hi | input | 1 | Comparator: high while capacitor voltage is above threshold |
| chg_cycles | input | CHG_W | Charge interval length in cycles (0 treated as 1) |
| tmo_limit | input | TIME_W | Discharge cycle limit per phase |
| r_ref | input | RREF_W | Reference resistance value |
| chg_en | output | 1 | Capacitor charge switch |
| sel_unk | output | 1 | Discharge path through unknown resistor |
| sel_ref | output | 1 | Discharge path through reference resistor |
| busy | output | 1 | Measurement in progress |
| res_valid | output | 1 | One-cycle strobe: `res_ohm` is valid |
| res_ohm | output | TIME_W+RREF_W | Computed unknown resistance |
| tmo_err | output | 1 | One-cycle strobe: a discharge phase timed out |

## Verification
The bench predicts every output on every cycle and compares them one by one. Its targets are the off-by-one points in the timing:
- A trip in the very first discharge cycle. A counter that starts at the wrong value would report t_u or t_r one too large or too small, and the quotient would shift.
- A trip in the same cycle the limit is reached. A design that gives precedence the wrong way would raise `tmo_err` instead of producing a result.
- A zero charge length and a zero limit. A wrong design would hang or skip the phase.
- A `start` pulse during discharge. A wrong design would restart and lengthen the phase.
- A comparator held low while charging. A design that looks at the comparator outside the discharge phases would end the phase early.
- Large ratios and results with a remainder. These expose divider bit-order and truncation errors.

// File: rtl/rr_pkg.sv
package rr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_CHG1 = 3'd1,
      ST_DIS1 = 3'd2,
      ST_GAP  = 3'd3,
      ST_CHG2 = 3'd4,
      ST_DIS2 = 3'd5,
      ST_DIV  = 3'd6
   } rr_state_e;
endpackage

// File: rtl/rr_cycle_timer.sv
module rr_cycle_timer #(
   parameter int W = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] cnt
);
   if (W < 2) begin : g_bad_w
      $error("rr_cycle_timer: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (en)
         cnt <= cnt + W'(1);
   end
endmodule

// File: rtl/rr_seq_divider.sv
module rr_seq_divider #(
   parameter int NW = 32,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [NW-1:0] num,
   input  logic [DW-1:0] den,
   output logic          done,
   output logic [NW-1:0] quo
);
   localparam int CNTW = $clog2(NW + 1);

   if (NW < 2 || DW < 1) begin : g_bad_w
      $error("rr_seq_divider: NW must be >= 2 and DW >= 1");
   end

   logic [DW-1:0]   rem_q;
   logic [DW-1:0]   den_q;
   logic [CNTW-1:0] left_q;
   logic [DW:0]     trial;
   logic            fits;

   always_comb begin
      trial = {rem_q, quo[NW-1]};
      fits  = (trial >= {1'b0, den_q});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         den_q  <= '0;
         left_q <= '0;
         quo    <= '0;
         done   <= 1'b0;
      end else if (go) begin
         rem_q  <= '0;
         den_q  <= den;
         left_q <= CNTW'(NW);
         quo    <= num;
         done   <= 1'b0;
      end else if (left_q != '0) begin
         if (fits)
            rem_q <= DW'(trial - {1'b0, den_q});
         else
            rem_q <= trial[DW-1:0];
         quo    <= {quo[NW-2:0], fits};
         left_q <= left_q - CNTW'(1);
         done   <= (left_q == CNTW'(1));
      end else begin
         done <= 1'b0;
      end
   end
endmodule

// File: rtl/rr_ratio_meter.sv
module rr_ratio_meter
   import rr_pkg::*;
#(
   parameter int TIME_W = 16,
   parameter int CHG_W  = 8,
   parameter int RREF_W = 16,
   localparam int OUT_W = TIME_W + RREF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              comp_hi,
   input  logic [CHG_W-1:0]  chg_cycles,
   input  logic [TIME_W-1:0] tmo_limit,
   input  logic [RREF_W-1:0] r_ref,
   output logic              chg_en,
   output logic              sel_unk,
   output logic              sel_ref,
   output logic              busy,
   output logic              res_valid,
   output logic [OUT_W-1:0]  res_ohm,
   output logic              tmo_err
);
   localparam int KW = ((TIME_W > CHG_W) ? TIME_W : CHG_W) + 1;

   if (TIME_W < 2) begin : g_bad_time
      $error("rr_ratio_meter: TIME_W must be at least 2");
   end
   if (CHG_W < 1) begin : g_bad_chg
      $error("rr_ratio_meter: CHG_W must be at least 1");
   end
   if (RREF_W < 1) begin : g_bad_rref
      $error("rr_ratio_meter: RREF_W must be at least 1");
   end

   rr_state_e         st_q, st_d;
   logic [KW-1:0]     cnt, cnt_nx;
   logic              chg_last, tmo_hit, trip, in_dis;
   logic [TIME_W-1:0] t_unk_q, t_ref_q;
   logic              div_go_q, div_done;
   logic [OUT_W-1:0]  div_num, div_quo;

   rr_cycle_timer #(.W(KW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st_d != st_q),
      .en    (st_q != ST_IDLE),
      .cnt   (cnt)
   );

   always_comb begin
      cnt_nx   = cnt + KW'(1);
      chg_last = (cnt_nx >= KW'(chg_cycles));
      tmo_hit  = (cnt_nx >= KW'(tmo_limit));
      trip     = !comp_hi;
      in_dis   = (st_q == ST_DIS1) || (st_q == ST_DIS2);
   end

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (start) st_d = ST_CHG1;
         ST_CHG1: if (chg_last) st_d = ST_DIS1;
         ST_DIS1: begin
            if (trip)         st_d = ST_GAP;
            else if (tmo_hit) st_d = ST_IDLE;
         end
         ST_GAP:  st_d = ST_CHG2;
         ST_CHG2: if (chg_last) st_d = ST_DIS2;
         ST_DIS2: begin
            if (trip)         st_d = ST_DIV;
            else if (tmo_hit) st_d = ST_IDLE;
         end
         ST_DIV:  if (div_done) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         t_unk_q   <= '0;
         t_ref_q   <= '0;
         div_go_q  <= 1'b0;
         tmo_err   <= 1'b0;
         res_valid <= 1'b0;
         res_ohm   <= '0;
      end else begin
         st_q     <= st_d;
         div_go_q <= (st_q == ST_DIS2) && trip;
         tmo_err  <= in_dis && !trip && tmo_hit;
         res_valid <= (st_q == ST_DIV) && div_done;
         if (st_q == ST_DIS1 && trip) t_unk_q <= cnt_nx[TIME_W-1:0];
         if (st_q == ST_DIS2 && trip) t_ref_q <= cnt_nx[TIME_W-1:0];
         if (st_q == ST_DIV && div_done) res_ohm <= div_quo;
      end
   end

   always_comb div_num = OUT_W'(t_unk_q) * OUT_W'(r_ref);

   rr_seq_divider #(.NW(OUT_W), .DW(TIME_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (div_go_q),
      .num   (div_num),
      .den   (t_ref_q),
      .done  (div_done),
      .quo   (div_quo)
   );

   always_comb begin
      chg_en  = (st_q == ST_CHG1) || (st_q == ST_CHG2);
      sel_unk = (st_q == ST_DIS1);
      sel_ref = (st_q == ST_DIS2);
      busy    = (st_q != ST_IDLE);
   end
endmodule

// File: rtl/rr_ratio_meter_chk.sv
module rr_ratio_meter_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic comp_hi,
   input logic chg_en,
   input logic sel_unk,
   input logic sel_ref,
   input logic busy,
   input logic res_valid,
   input logic tmo_err
);
   // R4
   excl_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_unk && sel_ref));

   // R4
   chg_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg_en |-> (!sel_unk && !sel_ref));

   // R4
   dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_unk && !comp_hi) |=> (!sel_ref && !chg_en && !sel_unk && busy));

   // R3
   trip_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_unk && !comp_hi) |=> !sel_unk);

   // R2
   start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> chg_en);

   // R6
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R6
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (!busy && !tmo_err));

   // R7
   tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_err |-> (!busy && !res_valid));
endmodule

bind rr_ratio_meter rr_ratio_meter_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .comp_hi   (comp_hi),
   .chg_en    (chg_en),
   .sel_unk   (sel_unk),
   .sel_ref   (sel_ref),
   .busy      (busy),
   .res_valid (res_valid),
   .tmo_err   (tmo_err)
);

// File: tb/sim_rr_ratio_meter.sv
`timescale 1ns/1ps
module sim_rr_ratio_meter;
   localparam int TW = 16;
   localparam int CW = 8;
   localparam int RW = 16;
   localparam int OW = TW + RW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          comp_hi = 1'b1;
   logic [CW-1:0] chg_cycles = '0;
   logic [TW-1:0] tmo_limit = '0;
   logic [RW-1:0] r_ref = '0;
   logic          chg_en, sel_unk, sel_ref, busy, res_valid, tmo_err;
   logic [OW-1:0] res_ohm;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   rr_ratio_meter #(.TIME_W(TW), .CHG_W(CW), .RREF_W(RW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .comp_hi(comp_hi),
      .chg_cycles(chg_cycles), .tmo_limit(tmo_limit), .r_ref(r_ref),
      .chg_en(chg_en), .sel_unk(sel_unk), .sel_ref(sel_ref), .busy(busy),
      .res_valid(res_valid), .res_ohm(res_ohm), .tmo_err(tmo_err)
   );

   task automatic chk(input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t",
                  req, what, act, exp, $time);
      end
   endtask

   task automatic expect_out(input string req, input bit c, input bit u,
                             input bit r, input bit b, input bit v, input bit e);
      chk(req, "chg_en", chg_en, c);
      chk(req, "sel_unk", sel_unk, u);
      chk(req, "sel_ref", sel_ref, r);
      chk(req, "busy", busy, b);
      chk(req, "res_valid", res_valid, v);
      chk(req, "tmo_err", tmo_err, e);
   endtask

   // Runs one measurement from the idle state, checking every cycle.
   // tu/tr = discharge cycle in which comparator trips (0: never).
   task automatic measure(input int l, input int tu, input int tr, input int lim,
                          input longint rref, input bit poke);
      int lx;
      int eff;
      lx  = (l == 0) ? 1 : l;
      eff = (lim == 0) ? 1 : lim;
      chg_cycles = CW'(l);
      tmo_limit  = TW'(lim);
      r_ref      = RW'(rref);
      comp_hi    = 1'b0;
      start      = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < lx; i++) begin
         // R2 and R10: charge holds regardless of a low comparator
         expect_out("R2", 1, 0, 0, 1, 0, 0);
         comp_hi = 1'b0;
         @(negedge clk);
      end
      for (int k = 1; ; k++) begin
         expect_out("R3", 0, 1, 0, 1, 0, 0);
         if (poke && k == 1) start = 1'b1;   // R9
         comp_hi = (k != tu);
         @(negedge clk);
         start = 1'b0;
         if (k == tu) break;                 // R8 when k == eff
         if (k >= eff) begin
            expect_out("R7", 0, 0, 0, 0, 0, 1);
            @(negedge clk);
            expect_out("R7", 0, 0, 0, 0, 0, 0);
            return;
         end
      end
      expect_out("R4", 0, 0, 0, 1, 0, 0);
      comp_hi = 1'b0;
      @(negedge clk);
      for (int i = 0; i < lx; i++) begin
         expect_out("R5", 1, 0, 0, 1, 0, 0);
         comp_hi = 1'b0;                     // R10
         @(negedge clk);
      end
      for (int k = 1; ; k++) begin
         expect_out("R5", 0, 0, 1, 1, 0, 0);
         if (poke && k == 1) start = 1'b1;   // R9
         comp_hi = (k != tr);
         @(negedge clk);
         start = 1'b0;
         if (k == tr) break;
         if (k >= eff) begin
            expect_out("R7", 0, 0, 0, 0, 0, 1);
            @(negedge clk);
            expect_out("R7", 0, 0, 0, 0, 0, 0);
            return;
         end
      end
      for (int i = 0; i < OW + 2; i++) begin
         expect_out("R6", 0, 0, 0, 1, 0, 0);
         comp_hi = i[0];                     // R10: ignored while dividing
         @(negedge clk);
      end
      expect_out("R6", 0, 0, 0, 0, 1, 0);
      chk("R6", "res_ohm", longint'(res_ohm), (rref * longint'(tu)) / longint'(tr));
      comp_hi = 1'b1;
      @(negedge clk);
      expect_out("R6", 0, 0, 0, 0, 0, 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      expect_out("R1", 0, 0, 0, 0, 0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      expect_out("R1", 0, 0, 0, 0, 0, 0);
      measure(4, 10, 5, 100, 1000, 0);       // basic ratio 2
      measure(0, 1, 1, 50, 65535, 0);        // zero charge, first-cycle trips
      measure(3, 37, 200, 300, 4700, 1);     // remainder, start ignored
      measure(2, 0, 5, 6, 100, 0);           // R7 unknown phase timeout
      measure(2, 5, 0, 8, 100, 0);           // R7 reference phase timeout
      measure(1, 20, 20, 20, 1234, 0);       // R8 trip at the limit
      measure(1, 0, 0, 0, 99, 0);            // R7 zero limit
      measure(5, 1000, 3, 2000, 60000, 1);   // large quotient
      measure(2, 3, 7, 10, 1, 0);            // quotient zero
      finish_run();
   end
endmodule